// File: doc/BRIEF.md
# EDID Two-Wire Slave

This block lets an external two-wire (I2C) master read a 256-byte display-identification table, and write it when the host permits. Bus lines enter through synchronizers and are oversampled by the system clock. SDA is driven only low, by raising an output-enable. Standard-mode and fast-mode SCL rates are both far below the oversampling clock, so one design serves both.

A master first sends the slave address with R/W=0 and then a one-byte offset. It may follow with data bytes to write, or with a repeated START and the address with R/W=1 to read bytes in sequence from that offset. A small sideband register pair holds the slave address together with a write-protect flag, and an interface-off flag. A local write port fills the table before any bus use.

Top module: `edid_i2c_slave`

## Requirements
- R1: After reset SDA is released (`sda_oe`=0). The device register reads 0xA1: bits [7:1] hold the 7-bit address 0x50 and bit 0 is the write-protect flag, set. The off register is clear.
- R2: A START followed by the matching address with R/W=0 (last bit 0) is ACKed. The next byte is ACKed and becomes the current offset.
- R3: After a repeated START and the matching address with R/W=1, the slave ACKs and returns bytes MSB first, starting at the current offset. The offset advances by one after every byte. Without a new offset, a read continues from where the last transfer stopped.
- R4: The offset wraps from 0xFF to 0x00 during sequential access.
- R5: While device-register bit 0 is 1, data bytes after the offset are NACKed and the table is unchanged.
- R6: While device-register bit 0 is 0, each data byte is ACKed, stored at the current offset, and the offset advances.
- R7: A sideband write with `cfg_sel`=0 replaces the device register at run time. Traffic to any other address is not ACKed and SDA stays released for the whole transfer.
- R8: A sideband write with `cfg_sel`=1 and data bit 0 set turns the interface off. The slave then never drives SDA and stores nothing. Clearing the bit restores normal operation.
- R9: A NACK from the master after a read byte ends the transfer, and SDA stays released until the next START.
- R10: A STOP or START arriving in the middle of a byte aborts the transfer, and the partial byte is not stored. A STOP always releases SDA.
- R11: A pulse on `pre_we` writes `pre_data` into the table at `pre_addr`, and that byte is returned by a later bus read.
- R12: SDA changes only after a detected SCL falling edge. Operation is correct at SCL phase lengths of 10 and 40 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_wr | input | 1 | Sideband register write strobe |
| cfg_sel | input | 1 | 0 selects the device register, 1 the off register |
| cfg_wdata | input | 8 | Sideband write data |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 8 | Preload byte offset |
| pre_data | input | 8 | Preload byte value |

## Verification
The bench uses the default parameters: two synchronizer stages, a reset address of 0x50, and an 8-bit offset giving the full 256-byte table. That full depth puts the 0xFF-to-0x00 wrap within reach of an ordinary read. The bus model runs with SCL phases of 10 clocks and of 40 clocks, and the slower rate stands in for standard-mode timing. At the 10-clock rate the synchronizer and edge-detect latency takes a visible share of each SCL phase.

// File: rtl/edid_pkg.sv
// Shared types for the EDID two-wire slave.
// Assumes: one byte per bus transfer, MSB first.
package edid_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_OFFS,
        ST_OFFS_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } edid_state_e;

endpackage

// File: rtl/edid_bus_sync.sv
// Synchronizes SCL/SDA into the system clock and derives bus events.
// Assumes: SYNC_STAGES >= 2; an idle bus is high, so flops reset to 1.
module edid_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_s;

    // Shift the raw lines through the synchronizer chain and keep one old sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[SYNC_STAGES-1];
            sda_prev <= sda_pipe[SYNC_STAGES-1];
        end
    end

    // Decode edges and START/STOP conditions from the synchronized samples.
    always_comb begin
        scl_s     = scl_pipe[SYNC_STAGES-1];
        sda_s     = sda_pipe[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        bus_start = scl_s & scl_prev & sda_prev & ~sda_s;
        bus_stop  = scl_s & scl_prev & ~sda_prev & sda_s;
    end

endmodule

// File: rtl/edid_mem.sv
// Byte table with one write port and one combinational read port.
// Assumes: the caller arbitrates write sources; contents are not reset.
module edid_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Store one byte per enabled cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Present the addressed byte without delay.
    always_comb begin
        rdata = cells[raddr];
    end

endmodule

// File: rtl/edid_i2c_fsm.sv
// Protocol engine: address match, offset capture, writes, sequential reads.
// Assumes: events come from edid_bus_sync; ADDR_W <= 8; no clock stretching.
module edid_i2c_fsm
    import edid_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [6:0]        dev_addr,
    input  logic              wr_allow,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ptr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              sda_oe
);
    localparam int                CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(BYTE_W);

    edid_state_e       state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] tx;
    logic              is_rd;
    logic              mack;

    // Advance the transfer on each decoded bus event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            tx        <= '0;
            ptr       <= '0;
            is_rd     <= 1'b0;
            mack      <= 1'b0;
            sda_oe    <= 1'b0;
            mem_we    <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (!enable || bus_stop) begin
                state  <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (bus_start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_OFFS, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + CNT_W'(1);
                        end else if (scl_fall && cnt == LAST) begin
                            if (state == ST_ADDR) begin
                                if (shreg[BYTE_W-1:1] == dev_addr) begin
                                    is_rd  <= shreg[0];
                                    sda_oe <= 1'b1;
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_OFFS) begin
                                ptr    <= shreg[ADDR_W-1:0];
                                sda_oe <= 1'b1;
                                state  <= ST_OFFS_ACK;
                            end else if (wr_allow) begin
                                mem_we    <= 1'b1;
                                mem_waddr <= ptr;
                                mem_wdata <= shreg;
                                ptr       <= ptr + ADDR_W'(1);
                                sda_oe    <= 1'b1;
                                state     <= ST_WDATA_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (is_rd) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_OFFS;
                            end
                        end
                    end
                    ST_OFFS_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            cnt    <= '0;
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            cnt <= cnt + CNT_W'(1);
                        end else if (scl_fall) begin
                            if (cnt == LAST) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + ADDR_W'(1);
                                state  <= ST_RACK;
                            end else begin
                                sda_oe <= ~tx[BYTE_W-2];
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                cnt    <= '0;
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R10: a STOP always leaves SDA released on the next cycle.
    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_oe);

    // R12: SDA is only pulled low right after a detected SCL falling edge.
    p_drive_after_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R7: an ACK for an address is only given right after a falling edge
    // that closes a complete byte.
    p_ack_after_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && $past(state) == ST_ADDR) |-> $past(cnt) == LAST);

endmodule

// File: rtl/edid_i2c_slave.sv
// Top: sideband registers, write-port arbitration, sync, engine and table.
// Assumes: preload and bus writes may collide; the preload port wins.
module edid_i2c_slave #(
    parameter int         ADDR_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEF_DEV     = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [7:0]        cfg_wdata,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [7:0]        pre_data
);
    import edid_pkg::*;

    logic [7:0]        dev_q;
    logic              off_q;
    logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic [ADDR_W-1:0] ptr;
    logic [BYTE_W-1:0] rd_data;
    logic              bus_we;
    logic [ADDR_W-1:0] bus_waddr;
    logic [BYTE_W-1:0] bus_wdata;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [BYTE_W-1:0] mem_wdata;

    // Hold the device address/protect register and the interface-off flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_q <= {DEF_DEV, 1'b1};
            off_q <= 1'b0;
        end else if (cfg_wr) begin
            if (cfg_sel) begin
                off_q <= cfg_wdata[0];
            end else begin
                dev_q <= cfg_wdata;
            end
        end
    end

    // Give the preload port priority over bus writes on the single write port.
    always_comb begin
        mem_we    = pre_we | bus_we;
        mem_waddr = pre_we ? pre_addr : bus_waddr;
        mem_wdata = pre_we ? pre_data : bus_wdata;
    end

    edid_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop)
    );

    edid_i2c_fsm #(.ADDR_W(ADDR_W)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (~off_q),
        .dev_addr (dev_q[7:1]),
        .wr_allow (~dev_q[0]),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop),
        .rd_data  (rd_data),
        .ptr      (ptr),
        .mem_we   (bus_we),
        .mem_waddr(bus_waddr),
        .mem_wdata(bus_wdata),
        .sda_oe   (sda_oe)
    );

    edid_mem #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) i_mem (
        .clk  (clk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(mem_wdata),
        .raddr(ptr),
        .rdata(rd_data)
    );

    // R8: with the interface off, SDA is released from the next cycle on.
    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        off_q |=> !sda_oe);

    // R5: a bus write only follows a cycle in which protection was clear.
    p_no_write_protected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> !$past(dev_q[0]));

endmodule

// File: tb/test_edid_i2c_slave.sv
// Bench: behavioural bus master plus a reference table and offset model.
module test_edid_i2c_slave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       cfg_wr = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       pre_we = 1'b0;
    logic [7:0] pre_addr = 8'h00;
    logic [7:0] pre_data = 8'h00;
    logic       sda_oe;
    logic       sda_line;

    int         n_chk = 0;
    int         n_fail = 0;
    int         q = 10;
    logic [7:0] ref_mem [256];
    logic [7:0] ref_ptr = 8'h00;
    logic [7:0] wq [$];
    logic       quiet_on = 1'b0;
    int         quiet_bad = 0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    edid_i2c_slave i_edid_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data)
    );

    // Per-clock comparison: during a window where the model expects silence, SDA must be free.
    always @(negedge clk) begin
        if (quiet_on && sda_oe) quiet_bad++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(q);
        sda_m = 1'b0; tick(q);
        scl_m = 1'b0; tick(q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(q);
        scl_m = 1'b1; tick(q);
        sda_m = 1'b0; tick(q);
        scl_m = 1'b0; tick(q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(q);
        scl_m = 1'b1; tick(q);
        sda_m = 1'b1; tick(q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            sda_m = b[i]; tick(q);
            scl_m = 1'b1; tick(2 * q);
            scl_m = 1'b0; tick(q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(q);
        scl_m = 1'b1; tick(q);
        ack = ~sda_line; tick(q);
        scl_m = 1'b0; tick(q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(q);
            scl_m = 1'b1; tick(q);
            b[i] = sda_line; tick(q);
            scl_m = 1'b0;
        end
        tick(q);
        sda_m = ~give_ack; tick(q);
        scl_m = 1'b1; tick(2 * q);
        scl_m = 1'b0; tick(q);
        sda_m = 1'b1;
    endtask

    task automatic cfg_write(input logic sel, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d; tick(1);
        cfg_wr = 1'b0; tick(1);
    endtask

    // Read n bytes from the model's current offset; the last one gets a NACK.
    task automatic read_n(input int n, input string tg);
        logic [7:0] b;
        int base;
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i < n - 1);
            chk(tg, b, ref_mem[ref_ptr]);
            ref_ptr = ref_ptr + 8'd1;
        end
        base = quiet_bad; quiet_on = 1'b1; tick(2 * q); quiet_on = 1'b0;
        chk("R9 release after master NACK", quiet_bad - base, 0);
        bus_stop();
    endtask

    task automatic read_from(input logic [6:0] a, input logic [7:0] off, input int n, input string tg);
        logic ack;
        bus_start();
        send_byte({a, 1'b0}, ack); chk("R2 address ack", ack, 1);
        send_byte(off, ack);       chk("R2 offset ack", ack, 1);
        ref_ptr = off;
        bus_rstart();
        send_byte({a, 1'b1}, ack); chk("R3 read address ack", ack, 1);
        read_n(n, tg);
    endtask

    task automatic write_at(input logic [6:0] a, input logic [7:0] off, input logic exp_ack, input string tg);
        logic ack;
        bus_start();
        send_byte({a, 1'b0}, ack); chk("R2 address ack", ack, 1);
        send_byte(off, ack);       chk("R2 offset ack", ack, 1);
        ref_ptr = off;
        foreach (wq[i]) begin
            send_byte(wq[i], ack);
            chk(tg, ack, exp_ack);
            if (!exp_ack) break;
            ref_mem[ref_ptr] = wq[i];
            ref_ptr = ref_ptr + 8'd1;
        end
        bus_stop();
    endtask

    // A full write attempt during which the model expects SDA never driven.
    task automatic silent_txn(input logic [6:0] a, input string tg);
        logic ack;
        int base;
        base = quiet_bad; quiet_on = 1'b1;
        bus_start();
        send_byte({a, 1'b0}, ack); chk(tg, ack, 0);
        send_byte(8'h40, ack);
        send_byte(8'hEE, ack);
        bus_stop();
        quiet_on = 1'b0;
        chk(tg, quiet_bad - base, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        logic       ack;
        tick(5);
        chk("R1 sda released in reset", sda_oe, 0);
        rst_n = 1'b1; tick(2);
        chk("R1 sda released after reset", sda_oe, 0);

        // R11: preload the whole table through the local port.
        for (int i = 0; i < 256; i++) begin
            pre_we = 1'b1; pre_addr = 8'(i); pre_data = 8'(i) ^ 8'h5A;
            ref_mem[i] = 8'(i) ^ 8'h5A;
            tick(1);
        end
        pre_we = 1'b0; tick(2);

        read_from(7'h50, 8'h10, 4, "R11 preload read / R3 sequence");

        // R5: default protection NACKs data and keeps the table.
        wq = '{8'h11};
        write_at(7'h50, 8'h20, 1'b0, "R5 protected data nack");
        read_from(7'h50, 8'h20, 1, "R5 table unchanged");

        // R6: clear protection and write three bytes.
        cfg_write(1'b0, 8'hA0);
        wq = '{8'hC3, 8'h3C, 8'h99};
        write_at(7'h50, 8'h30, 1'b1, "R6 data ack");
        read_from(7'h50, 8'h30, 3, "R6 stored data");

        // R4: wrap past the top of the table.
        read_from(7'h50, 8'hFE, 4, "R4 wrap");

        // R3: current-offset read without a new offset.
        bus_start();
        send_byte({7'h50, 1'b1}, ack); chk("R3 current read ack", ack, 1);
        read_n(2, "R3 current offset continue");

        // R7: move the address; the old one is ignored.
        cfg_write(1'b0, {7'h62, 1'b0});
        silent_txn(7'h50, "R7 old address ignored");
        read_from(7'h62, 8'h30, 1, "R7 new address read");

        // R8: interface off ignores everything, then recovers.
        cfg_write(1'b1, 8'h01);
        silent_txn(7'h62, "R8 off ignores traffic");
        cfg_write(1'b1, 8'h00);
        read_from(7'h62, 8'h40, 1, "R8 nothing stored while off");

        // R10: STOP in the middle of a data byte.
        bus_start();
        send_byte({7'h62, 1'b0}, ack); chk("R2 address ack", ack, 1);
        send_byte(8'h50, ack);         chk("R2 offset ack", ack, 1);
        send_bits(8'hAB, 4);
        bus_stop();
        chk("R10 sda free after stop", sda_oe, 0);
        read_from(7'h62, 8'h50, 1, "R10 mid-byte stop not stored");

        // R10: START in the middle of a data byte, then read.
        bus_start();
        send_byte({7'h62, 1'b0}, ack); chk("R2 address ack", ack, 1);
        send_byte(8'h51, ack);         chk("R2 offset ack", ack, 1);
        send_bits(8'hAB, 4);
        bus_rstart();
        send_byte({7'h62, 1'b1}, ack); chk("R10 restart address ack", ack, 1);
        ref_ptr = 8'h51;
        read_n(1, "R10 mid-byte start not stored");

        // R12: slower bus phases.
        q = 40;
        read_from(7'h62, 8'h30, 2, "R12 slow bus read");
        q = 10;

        report();
    end

endmodule